// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Mode Model

A synthesizable, clocked behavioural model of a byte-wide one-time-programmable memory whose depth is set by a parameter. It serves as a target for programmer and reader logic under test. The pins are modelled as digital signals. Chip enable, output enable and program strobe are active low. Two flags stand in for the high voltages that a real part would see on its programming supply pin and on address bit 9. All inputs are sampled on the rising clock edge. The data output and its drive-enable indicator are registered, so they show the result one cycle after the inputs are sampled.

The model decodes the operating mode from the control inputs. It returns stored bytes or identifier bytes. It applies program pulses, and a pulse can only clear bits. A parameter sets how many consecutive pulses to the same address a location needs before it takes the new value. This lets a programmer's retry loop be exercised. A synchronous erase input restores the whole array to all ones.

Top module: `otp_rom_model`

## Requirements
- R1: After reset, every location reads FFh.
- R2: With chip enable low, output enable low, and both voltage flags clear, the byte stored at the address appears on dout_o with dout_en_o high in the cycle after the inputs are sampled.
- R3: With chip enable high, dout_en_o is low and dout_o is 00h whatever the other inputs are, and no location is written.
- R4: With chip enable low, output enable high and the supply flag clear, dout_en_o is low and dout_o is 00h.
- R5: A program pulse is a sampled cycle with the supply flag set, chip enable low, program strobe low and output enable high. In that cycle the outputs are disabled. Once PULSES_NEEDED consecutive pulses have hit the same address, that location is updated.
- R6: An update stores the bitwise AND of the current contents and din_i, so a bit that is 0 never returns to 1.
- R7: Fewer than PULSES_NEEDED pulses leave the location unchanged. A pulse to a different address restarts the count. Cycles that are not pulses do not clear the count.
- R8: With the supply flag set, chip enable low and output enable low, the stored byte is driven, whatever the program strobe level, and nothing is written.
- R9: With the address-9 flag set, the supply flag clear, chip enable and output enable low, and address bits above bit 0 all zero, the output is 01h when address bit 0 is 0 and 0Eh when it is 1.
- R10: Every identifier byte has odd parity over all eight bits, and bit 7 serves as the parity bit.
- R11: With the address-9 flag set but some address bit above bit 0 set, normal read data is returned.
- R12: An erase_all_i sampled high sets every location to FFh at that edge, takes priority over a program pulse in the same cycle, and clears any partial pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; array starts erased |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| pgm_ni | input | 1 | Program strobe, active low |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | 8 | Data to program |
| vpp_hi_i | input | 1 | Programming supply high-voltage flag |
| a9_hi_i | input | 1 | Address bit 9 high-voltage flag (identifier mode) |
| erase_all_i | input | 1 | Synchronous whole-array erase |
| dout_o | output | 8 | Output byte; 00h when not driven |
| dout_en_o | output | 1 | High when the outputs would be driven |

## Verification
Four rules are checked by assertions on every cycle: no update ever sets a bit, an erase leaves the addressed byte at FFh, any cycle with chip enable high is followed by disabled outputs, and every identifier byte driven out has odd parity. The pulse counter is also held inside its range. Only the bench scenarios can show the behaviour that depends on order. That covers the count of pulses, a restart when the address changes, verify cycles that never write, the exact identifier values, the fallback to a normal read when other address bits are set, and erase winning over a pulse in the same cycle.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLE,
    MODE_READ,
    MODE_IDENT,
    MODE_PROGRAM,
    MODE_VERIFY
  } mode_e;

  // Bit 7 chosen so the whole byte has an odd number of ones
  function automatic logic [7:0] odd_parity_byte(input logic [6:0] low7);
    return {~^low7, low7};
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_rom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              pgm_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vpp_hi_i,
  input  logic              a9_hi_i,
  output mode_e             mode_o
);

  logic upper_zero;
  assign upper_zero = (addr_i[ADDR_W-1:1] == '0);

  always_comb begin
    if (ce_ni) begin
      mode_o = MODE_STANDBY;
    end else if (vpp_hi_i) begin
      if (!oe_ni)       mode_o = MODE_VERIFY;
      else if (!pgm_ni) mode_o = MODE_PROGRAM;
      else              mode_o = MODE_DISABLE;
    end else if (oe_ni) begin
      mode_o = MODE_DISABLE;
    end else if (a9_hi_i && upper_zero) begin
      mode_o = MODE_IDENT;
    end else begin
      mode_o = MODE_READ;
    end
  end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W        = 10,
  parameter int PULSES_NEEDED = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              erase_all_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        din_i,
  output logic [7:0]        rd_word_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PULSES_NEEDED + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(PULSES_NEEDED);

  logic [7:0]        cells [DEPTH];
  logic [ADDR_W-1:0] trk_addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              same_addr;
  logic              fire;

  assign rd_word_o = cells[addr_i];
  assign same_addr = (addr_i == trk_addr_q) && (cnt_q != '0);
  assign cnt_nxt   = same_addr ? cnt_q + 1'b1 : CNT_W'(1);
  assign fire      = pulse_i && !erase_all_i && (cnt_nxt == CNT_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_addr_q <= '0;
      cnt_q      <= '0;
    end else if (erase_all_i) begin
      cnt_q      <= '0;
    end else if (pulse_i) begin
      trk_addr_q <= addr_i;
      cnt_q      <= fire ? '0 : cnt_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (erase_all_i) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (fire) begin
      cells[addr_i] <= cells[addr_i] & din_i;
    end
  end

  // Checker state: previous address, contents and events
  logic [ADDR_W-1:0] chk_addr_q;
  logic [7:0]        chk_word_q;
  logic              chk_fire_q;
  logic              chk_erase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_addr_q  <= '0;
      chk_word_q  <= 8'hFF;
      chk_fire_q  <= 1'b0;
      chk_erase_q <= 1'b0;
    end else begin
      chk_addr_q  <= addr_i;
      chk_word_q  <= rd_word_o;
      chk_fire_q  <= fire;
      chk_erase_q <= erase_all_i;
    end
  end

  // R6
  no_set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_fire_q |-> ((cells[chk_addr_q] & ~chk_word_q) == 8'h00));

  // R12
  erase_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_erase_q |-> (cells[chk_addr_q] == 8'hFF));

  // R7
  pulse_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_LIM);

endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage
  import otp_rom_pkg::*;
#(
  parameter logic [6:0] MFR_LOW7 = 7'h01,
  parameter logic [6:0] DEV_LOW7 = 7'h0E
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mode_e      mode_i,
  input  logic       addr0_i,
  input  logic [7:0] rd_word_i,
  output logic [7:0] dout_o,
  output logic       dout_en_o
);

  localparam logic [7:0] MFR_CODE = odd_parity_byte(MFR_LOW7);
  localparam logic [7:0] DEV_CODE = odd_parity_byte(DEV_LOW7);

  logic [7:0] data_nxt;
  logic       en_nxt;
  logic       ident_q;

  always_comb begin
    en_nxt   = 1'b0;
    data_nxt = 8'h00;
    unique case (mode_i)
      MODE_READ, MODE_VERIFY: begin
        en_nxt   = 1'b1;
        data_nxt = rd_word_i;
      end
      MODE_IDENT: begin
        en_nxt   = 1'b1;
        data_nxt = addr0_i ? DEV_CODE : MFR_CODE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o    <= 8'h00;
      dout_en_o <= 1'b0;
      ident_q   <= 1'b0;
    end else begin
      dout_o    <= data_nxt;
      dout_en_o <= en_nxt;
      ident_q   <= (mode_i == MODE_IDENT);
    end
  end

  // R10
  ident_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ident_q && dout_en_o) |-> (^dout_o));

  // R4
  quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_en_o |-> (dout_o == 8'h00));

endmodule

// File: rtl/otp_rom_model.sv
module otp_rom_model
  import otp_rom_pkg::*;
#(
  parameter int         ADDR_W        = 10,
  parameter int         PULSES_NEEDED = 2,
  parameter logic [6:0] MFR_LOW7      = 7'h01,
  parameter logic [6:0] DEV_LOW7      = 7'h0E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              pgm_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        din_i,
  input  logic              vpp_hi_i,
  input  logic              a9_hi_i,
  input  logic              erase_all_i,
  output logic [7:0]        dout_o,
  output logic              dout_en_o
);

  mode_e      mode;
  logic [7:0] rd_word;

  otp_mode_decode #(.ADDR_W(ADDR_W)) u_decode (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .pgm_ni   (pgm_ni),
    .addr_i   (addr_i),
    .vpp_hi_i (vpp_hi_i),
    .a9_hi_i  (a9_hi_i),
    .mode_o   (mode)
  );

  otp_cell_array #(.ADDR_W(ADDR_W), .PULSES_NEEDED(PULSES_NEEDED)) u_cells (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_i     (mode == MODE_PROGRAM),
    .erase_all_i (erase_all_i),
    .addr_i      (addr_i),
    .din_i       (din_i),
    .rd_word_o   (rd_word)
  );

  otp_out_stage #(.MFR_LOW7(MFR_LOW7), .DEV_LOW7(DEV_LOW7)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .addr0_i   (addr_i[0]),
    .rd_word_i (rd_word),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o)
  );

  // R3
  standby_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> !dout_en_o);

endmodule

// File: tb/otp_rom_model_test.sv
module otp_rom_model_test;

  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_ni = 1'b1, oe_ni = 1'b1, pgm_ni = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        din = 8'hFF;
  logic              vpp = 1'b0, a9 = 1'b0, erase = 1'b0;
  logic [7:0]        dout;
  logic              dout_en;

  always #2ns clk = ~clk;

  otp_rom_model #(.ADDR_W(ADDR_W), .PULSES_NEEDED(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .pgm_ni(pgm_ni),
    .addr_i(addr), .din_i(din), .vpp_hi_i(vpp), .a9_hi_i(a9),
    .erase_all_i(erase), .dout_o(dout), .dout_en_o(dout_en)
  );

  typedef struct {
    bit         chk;
    bit         par;
    bit         en;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  task automatic cyc(input bit c, input bit o, input bit p, input int a,
                     input logic [7:0] d, input bit v, input bit h, input bit e,
                     input bit chk, input bit en, input logic [7:0] data,
                     input string tag, input bit par = 0);
    exp_t it;
    @(negedge clk);
    ce_ni = c; oe_ni = o; pgm_ni = p; addr = ADDR_W'(a); din = d;
    vpp = v; a9 = h; erase = e;
    it.chk = chk; it.en = en; it.data = data; it.tag = tag; it.par = par;
    q.push_back(it);
  endtask

  task automatic rd(input int a, input logic [7:0] d, input string tag);
    cyc(0, 0, 1, a, 8'hFF, 0, 0, 0, 1, 1, d, tag);
  endtask
  task automatic pulse(input int a, input logic [7:0] d, input string tag);
    cyc(0, 1, 0, a, d, 1, 0, 0, 1, 0, 8'h00, tag);
  endtask
  task automatic verify(input int a, input logic [7:0] d, input string tag);
    cyc(0, 0, 1, a, 8'h00, 1, 0, 0, 1, 1, d, tag);
  endtask

  // Monitor: compare one cycle after each driven cycle
  initial begin
    forever begin
      @(posedge clk); #1ns;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        if (it.chk) begin
          checks++;
          if (dout_en !== it.en || dout !== it.data) begin
            failures++;
            $display("FAIL %s: en=%0b dout=%02h expected en=%0b dout=%02h",
                     it.tag, dout_en, dout, it.en, it.data);
          end
        end
        if (it.par) begin
          checks++;
          if (^dout !== 1'b1) begin
            failures++;
            $display("FAIL R10: parity of %02h is %0b expected 1", dout, ^dout);
          end
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1ns;
    checks++;
    if (dout_en !== 1'b0 || dout !== 8'h00) begin
      failures++;
      $display("FAIL R3 reset outputs: en=%0b dout=%02h expected en=0 dout=00", dout_en, dout);
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    rd(0, 8'hFF, "R1 addr0");
    rd(1023, 8'hFF, "R1 top");
    rd(5, 8'hFF, "R2 addr5");

    // R5 / R7: first pulse alone does not update
    pulse(5, 8'hA5, "R5 outputs off during pulse");
    verify(5, 8'hFF, "R7 one pulse no change");
    pulse(5, 8'hA5, "R5 second pulse");
    verify(5, 8'hA5, "R5 updated after two pulses");
    // R6: ones cannot be restored, AND merge
    pulse(5, 8'hFF, "R6 pulse ff");
    pulse(5, 8'hFF, "R6 pulse ff");
    rd(5, 8'hA5, "R6 ones not restored");
    pulse(5, 8'h0F, "R6 pulse 0f");
    pulse(5, 8'h0F, "R6 pulse 0f");
    rd(5, 8'h05, "R6 and merge");

    // R7: address change restarts count
    pulse(7, 8'h00, "R7 addr7");
    pulse(8, 8'h00, "R7 addr8");
    pulse(7, 8'h00, "R7 addr7 again");
    rd(7, 8'hFF, "R7 restart kept addr7");
    rd(8, 8'hFF, "R7 restart kept addr8");
    pulse(7, 8'h00, "R7 addr7 third");
    rd(7, 8'h00, "R7 addr7 written");

    // R8: verify with strobe low writes nothing
    cyc(0, 0, 0, 9, 8'h00, 1, 0, 0, 1, 1, 8'hFF, "R8 verify strobe low");
    cyc(0, 0, 0, 9, 8'h00, 1, 0, 0, 1, 1, 8'hFF, "R8 verify strobe low");
    cyc(0, 0, 0, 9, 8'h00, 1, 0, 0, 1, 1, 8'hFF, "R8 verify strobe low");
    rd(9, 8'hFF, "R8 no write");

    // R3: standby with program conditions
    cyc(1, 1, 0, 10, 8'h00, 1, 0, 0, 1, 0, 8'h00, "R3 standby pgm");
    cyc(1, 0, 0, 10, 8'h00, 1, 1, 0, 1, 0, 8'h00, "R3 standby oe low");
    cyc(1, 1, 0, 10, 8'h00, 1, 0, 0, 1, 0, 8'h00, "R3 standby pgm");
    rd(10, 8'hFF, "R3 no write");

    // R4
    cyc(0, 1, 1, 5, 8'hFF, 0, 0, 0, 1, 0, 8'h00, "R4 output disable");
    cyc(0, 1, 0, 5, 8'hFF, 0, 0, 0, 1, 0, 8'h00, "R4 disable strobe low");

    // R9 / R10 identifier
    cyc(0, 0, 1, 0, 8'hFF, 0, 1, 0, 1, 1, 8'h01, "R9 manufacturer", 1);
    cyc(0, 0, 1, 1, 8'hFF, 0, 1, 0, 1, 1, 8'h0E, "R9 device", 1);

    // R11: other address bits set
    pulse(3, 8'h3C, "R11 prep");
    pulse(3, 8'h3C, "R11 prep");
    cyc(0, 0, 1, 3, 8'hFF, 0, 1, 0, 1, 1, 8'h3C, "R11 id flag normal read");
    cyc(0, 0, 1, 513, 8'hFF, 0, 1, 0, 1, 1, 8'hFF, "R11 bit9 set");

    // R12: erase over a pulse, and clears partial count
    pulse(11, 8'h00, "R12 partial");
    cyc(0, 1, 0, 5, 8'h00, 1, 0, 1, 1, 0, 8'h00, "R12 erase with pulse");
    rd(5, 8'hFF, "R12 addr5 erased");
    rd(7, 8'hFF, "R12 addr7 erased");
    rd(3, 8'hFF, "R12 addr3 erased");
    pulse(11, 8'h00, "R12 after erase");
    rd(11, 8'hFF, "R12 count cleared");

    cyc(1, 1, 1, 0, 8'hFF, 0, 0, 0, 0, 0, 8'h00, "idle");
    cyc(1, 1, 1, 0, 8'hFF, 0, 0, 0, 0, 0, 8'h00, "idle");
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule